// File: doc/BRIEF.md
# Serial DMA request encoder

This block collects up to eight active-high DMA request lines from expansion devices. It reports them to a host-side DMA controller over one active-low request wire. Each report is a serial frame. The frame starts with a low start bit, followed by one bit per channel, channel 0 first, with one bit per clock. A channel bit is low when that channel is pending. After the last channel bit the wire stays low for as long as the reported set is unchanged. Channel 4 is the cascade channel and is always reported as idle.

The block watches the host's active-low grant and the channel number that comes with it. It re-sends the frame whenever the pending set changes. Before each re-send it parks the wire high. A change seen before any grant gives a one-clock gap. A granted channel that drops its request gives a two-clock gap.

Two state machines run at the same time.

The frame sender has these states:
- IDLE: wire high.
- START: start bit.
- CHAN: channel bits.
- HOLD: wire low after the frame.
- GAP1: one-clock gap.
- GAP2A and GAP2B: two-clock gap.

Its transitions:
- IDLE→START when any channel is pending.
- START→CHAN.
- CHAN→HOLD after the last channel bit.
- HOLD→GAP2A on a granted-channel drop.
- HOLD→GAP1 on any other change in the pending set.
- GAP2A→GAP2B.
- GAP1 or GAP2B→START if any channel is pending, otherwise →IDLE.

The grant tracker has two states, FREE and OWNED:
- FREE→OWNED when the grant is low and it names a pending channel.
- OWNED→FREE when that channel's request falls. This transition also raises a one-cycle drop event.

If the drop event arrives during a frame, the sender holds it until HOLD.

Top module: `serial_dreq_encoder`

## Requirements
- R1: While reset is asserted, and after reset until a request is seen, req_n is high.
- R2: A frame is a low start bit, then eight channel bits, channel 0 first, one per clock; a channel bit is low (0) when the channel was pending at frame start and high (1) otherwise.
- R3: After the last channel bit req_n stays low while the pending set equals the set sent; when it changes, req_n goes high on the next clock.
- R4: Channel 4 is always sent as high (not pending), and a request on channel 4 alone starts no frame.
- R5: A new request that appears after a frame, with no granted channel having dropped, gives exactly one high clock, then a new frame listing all pending channels including the new one.
- R6: A reported request that falls with no grant gives exactly one high clock, then a frame without that channel, or an idle high line if none remain.
- R7: When a granted channel's request falls, req_n is high for exactly two clocks, then the frame is re-sent with the remaining channels, even if only one is left.
- R8: The grant tracker runs alongside the sender: a grant or a granted drop during a frame does not alter the frame's bits, and the drop is handled once the frame has ended.
- R9: Request inputs pass through two synchronizing flip-flops, so a request that rises before clock edge k starts a frame (req_n low) after edge k+2.
- R10: With no request pending, req_n stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dreq | input | NCH | Active-high DMA request lines, one per channel |
| gnt_n | input | 1 | Active-low grant from the host |
| gnt_chan | input | CHW | Channel number that the grant refers to |
| req_n | output | 1 | Active-low serial request line |

## Verification
Directed patterns are applied first:
- A quiet bus tells the idle line apart from spurious frames.
- A two-channel burst checks bit order and the hold phase.
- Adding one channel, and then removing one without a grant, separates the one-clock update path from the two-clock one.
- A lone cascade request shows channel 4 is masked.
- Granting a channel and then dropping it, with one other channel still pending, exercises the two-clock gap with a single survivor.
- A grant and drop timed inside a frame shows the frame finishes intact before the gap.

After that, random raises, drops and grant sessions mix these cases at arbitrary phases of the frame. Every cycle's line value is compared against a bench model.

// File: rtl/sdreq_pkg.sv
package sdreq_pkg;

    typedef enum logic [2:0] {
        RS_IDLE,
        RS_START,
        RS_CHAN,
        RS_HOLD,
        RS_GAP1,
        RS_GAP2A,
        RS_GAP2B
    } req_state_t;

    typedef enum logic {
        GS_FREE,
        GS_OWNED
    } gnt_state_t;

endpackage

// File: rtl/sdreq_sync.sv
module sdreq_sync #(
    parameter int W      = 8,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);

    logic [W-1:0] stage [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage[0] <= '0;
        end else begin
            stage[0] <= din;
        end
    end

    generate
        for (genvar k = 1; k < STAGES; k++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    stage[k] <= '0;
                end else begin
                    stage[k] <= stage[k-1];
                end
            end
        end
    endgenerate

    assign dout = stage[STAGES-1];

endmodule

// File: rtl/sdreq_grant_track.sv
module sdreq_grant_track
    import sdreq_pkg::*;
#(
    parameter int NCH = 8,
    parameter int CHW = $clog2(NCH)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NCH-1:0] pend,
    input  logic           gnt_n,
    input  logic [CHW-1:0] gnt_chan,
    output gnt_state_t     gstate,
    output logic           drop_evt
);

    gnt_state_t     gnext;
    logic [CHW-1:0] own_ch;
    logic [CHW-1:0] own_next;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gstate <= GS_FREE;
            own_ch <= '0;
        end else begin
            gstate <= gnext;
            own_ch <= own_next;
        end
    end

    // next state
    always_comb begin
        gnext    = gstate;
        own_next = own_ch;
        unique case (gstate)
            GS_FREE: begin
                if (!gnt_n && pend[gnt_chan]) begin
                    gnext    = GS_OWNED;
                    own_next = gnt_chan;
                end
            end
            GS_OWNED: begin
                if (!pend[own_ch]) begin
                    gnext = GS_FREE;
                end
            end
            default: gnext = GS_FREE;
        endcase
    end

    // outputs
    always_comb begin
        drop_evt = 1'b0;
        unique case (gstate)
            GS_FREE:  drop_evt = 1'b0;
            GS_OWNED: drop_evt = !pend[own_ch];
            default:  drop_evt = 1'b0;
        endcase
    end

endmodule

// File: rtl/sdreq_frame_tx.sv
module sdreq_frame_tx
    import sdreq_pkg::*;
#(
    parameter int NCH = 8,
    parameter int CHW = $clog2(NCH)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NCH-1:0] pend,
    input  logic           drop_evt,
    output req_state_t     rstate,
    output logic [CHW-1:0] idx,
    output logic [NCH-1:0] sent,
    output logic           drop_pend,
    output logic           req_n
);

    localparam logic [CHW-1:0] LAST = CHW'(NCH - 1);

    req_state_t     nstate;
    logic [CHW-1:0] nidx;
    logic [NCH-1:0] nsent;
    logic           ndrop;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rstate    <= RS_IDLE;
            idx       <= '0;
            sent      <= '0;
            drop_pend <= 1'b0;
        end else begin
            rstate    <= nstate;
            idx       <= nidx;
            sent      <= nsent;
            drop_pend <= ndrop;
        end
    end

    // next state
    always_comb begin
        nstate = rstate;
        nidx   = idx;
        nsent  = sent;
        ndrop  = drop_pend | drop_evt;
        unique case (rstate)
            RS_IDLE: begin
                ndrop = 1'b0;
                if (|pend) begin
                    nstate = RS_START;
                    nsent  = pend;
                end
            end
            RS_START: begin
                nstate = RS_CHAN;
                nidx   = '0;
            end
            RS_CHAN: begin
                if (idx == LAST) begin
                    nstate = RS_HOLD;
                end else begin
                    nidx = idx + 1'b1;
                end
            end
            RS_HOLD: begin
                if (drop_pend || drop_evt) begin
                    nstate = RS_GAP2A;
                    ndrop  = 1'b0;
                end else if (pend != sent) begin
                    nstate = RS_GAP1;
                end
            end
            RS_GAP2A: begin
                nstate = RS_GAP2B;
            end
            RS_GAP1, RS_GAP2B: begin
                if (|pend) begin
                    nstate = RS_START;
                    nsent  = pend;
                end else begin
                    nstate = RS_IDLE;
                end
            end
            default: nstate = RS_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        req_n = 1'b1;
        unique case (rstate)
            RS_IDLE, RS_GAP1, RS_GAP2A, RS_GAP2B: req_n = 1'b1;
            RS_START, RS_HOLD:                    req_n = 1'b0;
            RS_CHAN:                              req_n = ~sent[idx];
            default:                              req_n = 1'b1;
        endcase
    end

endmodule

// File: rtl/serial_dreq_encoder.sv
module serial_dreq_encoder
    import sdreq_pkg::*;
#(
    parameter int NCH         = 8,
    parameter int CHW         = $clog2(NCH),
    parameter int CASCADE     = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NCH-1:0] dreq,
    input  logic           gnt_n,
    input  logic [CHW-1:0] gnt_chan,
    output logic           req_n
);

    localparam logic [NCH-1:0] CH_MASK = ~(NCH'(1) << CASCADE);

    logic [NCH-1:0] dreq_sync;
    logic [NCH-1:0] pend_set;
    logic [NCH-1:0] sent_set;
    logic [CHW-1:0] chan_idx;
    logic           drop_evt;
    logic           drop_pend;
    req_state_t     rstate;
    gnt_state_t     gstate;

    sdreq_sync #(
        .W      (NCH),
        .STAGES (SYNC_STAGES)
    ) i_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (dreq),
        .dout  (dreq_sync)
    );

    assign pend_set = dreq_sync & CH_MASK;

    sdreq_grant_track #(
        .NCH (NCH),
        .CHW (CHW)
    ) i_grant (
        .clk      (clk),
        .rst_n    (rst_n),
        .pend     (pend_set),
        .gnt_n    (gnt_n),
        .gnt_chan (gnt_chan),
        .gstate   (gstate),
        .drop_evt (drop_evt)
    );

    sdreq_frame_tx #(
        .NCH (NCH),
        .CHW (CHW)
    ) i_tx (
        .clk       (clk),
        .rst_n     (rst_n),
        .pend      (pend_set),
        .drop_evt  (drop_evt),
        .rstate    (rstate),
        .idx       (chan_idx),
        .sent      (sent_set),
        .drop_pend (drop_pend),
        .req_n     (req_n)
    );

endmodule

// File: rtl/serial_dreq_encoder_chk.sv
module serial_dreq_encoder_chk
    import sdreq_pkg::*;
#(
    parameter int NCH     = 8,
    parameter int CHW     = $clog2(NCH),
    parameter int CASCADE = 4
) (
    input logic           clk,
    input logic           rst_n,
    input logic [NCH-1:0] dreq,
    input logic           gnt_n,
    input logic [CHW-1:0] gnt_chan,
    input logic           req_n,
    input req_state_t     rstate,
    input gnt_state_t     gstate,
    input logic [CHW-1:0] chan_idx,
    input logic [NCH-1:0] sent_set,
    input logic [NCH-1:0] pend_set,
    input logic           drop_evt,
    input logic           drop_pend
);

    localparam logic [NCH-1:0] CH_MASK = ~(NCH'(1) << CASCADE);

    logic [1:0] run_cyc;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_cyc <= '0;
        end else if (run_cyc != 2'd3) begin
            run_cyc <= run_cyc + 2'd1;
        end
    end

    AST_FRAME_SEQ: assert property (@(posedge clk) disable iff (!rst_n)
        rstate == RS_START |=> (rstate == RS_CHAN && chan_idx == '0)); // R2

    AST_HOLD_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (rstate == RS_CHAN && chan_idx == CHW'(NCH - 1)) |=> !req_n); // R3

    AST_CASCADE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (rstate == RS_CHAN && chan_idx == CHW'(CASCADE)) |-> req_n); // R4

    AST_CHANGE_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        (rstate == RS_HOLD && !drop_evt && !drop_pend && pend_set != sent_set)
        |=> rstate == RS_GAP1); // R5

    AST_DROP_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        (rstate == RS_HOLD && drop_evt) |=> rstate == RS_GAP2A); // R7

    AST_GAP_TWO: assert property (@(posedge clk) disable iff (!rst_n)
        rstate == RS_GAP2A |=> (rstate == RS_GAP2B && req_n)); // R7

    AST_GRANT_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
        (gstate == GS_FREE && !gnt_n && pend_set[gnt_chan]) |=> gstate == GS_OWNED); // R8

    AST_FRAME_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        rstate == RS_CHAN |-> $stable(sent_set)); // R8

    AST_SYNC_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
        run_cyc >= 2'd2 |-> pend_set == ($past(dreq, 2) & CH_MASK)); // R9

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (rstate == RS_IDLE && pend_set == '0) |=> req_n); // R10

endmodule

bind serial_dreq_encoder serial_dreq_encoder_chk i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .dreq      (dreq),
    .gnt_n     (gnt_n),
    .gnt_chan  (gnt_chan),
    .req_n     (req_n),
    .rstate    (rstate),
    .gstate    (gstate),
    .chan_idx  (chan_idx),
    .sent_set  (sent_set),
    .pend_set  (pend_set),
    .drop_evt  (drop_evt),
    .drop_pend (drop_pend)
);

// File: tb/test_serial_dreq_encoder.sv
`timescale 1ns/1ps
module test_serial_dreq_encoder;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] dreq = '0;
    logic       gnt_n = 1'b1;
    logic [2:0] gnt_chan = '0;
    logic       req_n;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    serial_dreq_encoder i_serial_dreq_encoder (
        .clk      (clk),
        .rst_n    (rst_n),
        .dreq     (dreq),
        .gnt_n    (gnt_n),
        .gnt_chan (gnt_chan),
        .req_n    (req_n)
    );

    // reference model; phases: 0 idle, 1 start, 2 chan, 3 hold, 4 gap1, 5 gap2a, 6 gap2b
    logic [7:0] m_s1, m_s2, m_sent;
    int         m_ph, m_idx;
    bit         m_dp, m_own_v, m_after_rst, m_from_idle, m_gap_new;
    int         m_own;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_s1 = '0; m_s2 = '0; m_sent = '0; m_ph = 0; m_idx = 0;
            m_dp = 0; m_own_v = 0; m_own = 0; m_after_rst = 1;
            m_from_idle = 0; m_gap_new = 0;
        end else begin
            bit evt;
            int nph;
            evt = m_own_v && !m_s2[m_own];
            nph = m_ph;
            if (m_ph != 0) m_dp = m_dp | evt;
            case (m_ph)
                0: begin
                    m_dp = 0;
                    if (m_s2 != 0) begin
                        nph = 1; m_sent = m_s2; m_from_idle = 1; m_after_rst = 0;
                    end
                end
                1: begin nph = 2; m_idx = 0; end
                2: begin
                    m_from_idle = 0;
                    if (m_idx == 7) nph = 3; else m_idx = m_idx + 1;
                end
                3: begin
                    if (m_dp) begin nph = 5; m_dp = 0; end
                    else if (m_s2 != m_sent) begin
                        nph = 4; m_gap_new = (m_s2 & ~m_sent) != 0;
                    end
                end
                5: nph = 6;
                default: begin
                    if (m_s2 != 0) begin nph = 1; m_sent = m_s2; end
                    else nph = 0;
                end
            endcase
            m_ph = nph;
            if (!m_own_v) begin
                if (!gnt_n && m_s2[gnt_chan]) begin m_own_v = 1; m_own = int'(gnt_chan); end
            end else if (!m_s2[m_own]) begin
                m_own_v = 0;
            end
            m_s2 = m_s1 & 8'hEF;
            m_s1 = dreq;
        end
    end

    function automatic bit exp_line(int ph, int idx, logic [7:0] snt);
        case (ph)
            1, 3:    return 1'b0;
            2:       return ~snt[idx];
            default: return 1'b1;
        endcase
    endfunction

    function automatic string req_tag();
        case (m_ph)
            0: return m_after_rst ? "R1" : "R10";
            1: return m_from_idle ? "R9" : "R2";
            2: return (m_idx == 4) ? "R4" : (!gnt_n || m_own_v) ? "R8" : "R2";
            3: return "R3";
            4: return m_gap_new ? "R5" : "R6";
            default: return "R7";
        endcase
    endfunction

    always @(negedge clk) begin
        if (!done) begin
            bit e;
            e = exp_line(m_ph, m_idx, m_sent);
            n_chk++;
            if (req_n !== e) begin
                n_bad++;
                $display("FAIL %s cycle %0d: req_n=%b expected %b", req_tag(), cyc, req_n, e);
            end
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !done) begin
            done = 1'b1;
            n_bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    task automatic wait_cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic grant_and_drop(int ch, int hold);
        gnt_chan = 3'(ch);
        gnt_n = 1'b0;
        wait_cyc(hold);
        gnt_n = 1'b1;
        dreq[ch] = 1'b0;
    endtask

    initial begin
        void'($urandom(32'h1234_5eed));
        wait_cyc(3);
        rst_n = 1'b1;
        wait_cyc(10);                       // R10 quiet
        dreq = 8'b0000_0110; wait_cyc(20);  // R2 R3 R9
        dreq[3] = 1'b1;      wait_cyc(20);  // R5
        dreq[1] = 1'b0;      wait_cyc(20);  // R6
        dreq[4] = 1'b1;      wait_cyc(20);  // R4
        grant_and_drop(2, 3); wait_cyc(20); // R7 single survivor
        dreq = 8'h10;        wait_cyc(20);  // R4 cascade alone
        dreq = 8'b0010_0001; wait_cyc(5);   // R8 grant mid-frame
        grant_and_drop(5, 2); wait_cyc(25);
        dreq = '0;           wait_cyc(20);
        for (int i = 0; i < 400; i++) begin
            int act, ch;
            act = $urandom_range(0, 3);
            ch  = $urandom_range(0, 7);
            case (act)
                0: dreq[ch] = 1'b1;
                1: dreq[ch] = 1'b0;
                2: if (dreq[ch] && ch != 4) grant_and_drop(ch, $urandom_range(1, 4));
                default: ;
            endcase
            wait_cyc($urandom_range(0, 16));
        end
        dreq = '0;
        wait_cyc(20);
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

endmodule